// File: doc/BRIEF.md
# Checked Chain Checksum Gate

This block guards a descriptor chain run by one transfer channel. While a transaction runs, it folds every issued source address into an address checksum and every read data word into a data checksum. Both checksums carry on from one descriptor to the next, so the final values cover the whole chain.

When the fetch logic has read the next descriptor, it presents that descriptor's expected-checksum word. The gate compares this word against the running address checksum. On a match, the gate emits a commit pulse and the chain goes on. On a mismatch, the gate withholds the commit and halts the chain. It also sets a sticky error flag and pulses an interrupt request. While halted, the gate freezes both checksums so that software can inspect them. The data checksum is reported but never compared.

Top module: `chain_sum_gate`

## Requirements
- R1: After reset, both checksum outputs equal 0xFFFFFFFF, and halt_o, err_o, irq_o and load_ok_o are 0.
- R2: On each cycle with addr_vld_i high while running, the address checksum becomes its CRC-32 update with addr_i. The update uses polynomial 0x04C11DB7, takes bits MSB first from bit 31 down to bit 0, applies no reflection and no final XOR, and is visible on addr_crc_o after that clock edge.
- R3: On each cycle with rdata_vld_i high while running, the data checksum gets the same CRC-32 update with rdata_i and is visible on data_crc_o.
- R4: chain_start_i reseeds both checksums to 0xFFFFFFFF and clears halt_o. It overrides any move or descriptor input in the same cycle.
- R5: desc_vld_i while running compares desc_sum_i with the address checksum held at the start of that cycle. If they are equal, load_ok_o is high for exactly the next cycle and irq_o stays 0.
- R6: A matching descriptor does not reseed either checksum; later moves continue from the accumulated value.
- R7: On a mismatching descriptor, load_ok_o stays 0, halt_o becomes 1, err_o becomes 1, and irq_o is high for exactly one cycle.
- R8: While halt_o is 1, move and descriptor inputs are ignored. Both checksums hold, and no load_ok_o or irq_o pulse occurs.
- R9: err_o stays 1 until a cycle with err_clr_i high and no new mismatch. A new mismatch wins over a clear in the same cycle, and clearing does not release halt_o.
- R10: The data checksum takes no part in the compare. A desc_sum_i equal only to data_crc_o is a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chain_start_i | input | 1 | Start of a new chain, reseeds checksums |
| addr_vld_i | input | 1 | A source address is issued this cycle |
| addr_i | input | 32 | Issued source address |
| rdata_vld_i | input | 1 | A read data word is returned this cycle |
| rdata_i | input | 32 | Read data word |
| desc_vld_i | input | 1 | Next descriptor has been fetched |
| desc_sum_i | input | 32 | Expected address checksum from the fetched descriptor |
| err_clr_i | input | 1 | Write-one-to-clear for the sticky error |
| addr_crc_o | output | 32 | Running address checksum |
| data_crc_o | output | 32 | Running read-data checksum |
| load_ok_o | output | 1 | One-cycle commit pulse for the fetched descriptor |
| halt_o | output | 1 | Chain stopped after a mismatch |
| err_o | output | 1 | Sticky checksum-mismatch error |
| irq_o | output | 1 | One-cycle error interrupt request |

## Verification
The assertions check the following on every cycle: an interrupt pulse lasts one cycle and always comes with a set error and a halt; both checksums freeze while halted; the error flag holds until cleared; a chain start reseeds the checksums; and a matching descriptor yields a commit. Only the bench's scenarios can show that the checksum values are correct CRC-32 results across a sequence of moves, and that accumulation carries across a committed descriptor. The same holds for the data checksum being excluded from the compare, and for a new error winning over a clear in the same cycle.

// File: rtl/chain_sum_pkg.sv
package chain_sum_pkg;
  localparam int unsigned SUM_W = 32;
  localparam logic [SUM_W-1:0] SUM_POLY = 32'h04C1_1DB7;
  localparam logic [SUM_W-1:0] SUM_INIT = 32'hFFFF_FFFF;

  typedef enum logic {
    CHAIN_RUN  = 1'b0,
    CHAIN_HALT = 1'b1
  } chain_state_e;
endpackage

// File: rtl/sum_accum.sv
module sum_accum #(
  parameter int unsigned     W    = 32,
  parameter logic [W-1:0]    POLY = '0,
  parameter logic [W-1:0]    INIT = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         seed_i,
  input  logic         hold_i,
  input  logic         upd_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] sum_q, sum_nxt;

  // MSB-first serial division, unrolled over the word
  always_comb begin
    logic [W-1:0] c;
    logic fb;
    c = sum_q;
    for (int i = W - 1; i >= 0; i--) begin
      fb = c[W-1] ^ word_i[i];
      c  = {c[W-2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    sum_nxt = c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sum_q <= INIT;
    else if (seed_i)  sum_q <= INIT;
    else if (hold_i)  sum_q <= sum_q;
    else if (upd_i)   sum_q <= sum_nxt;
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/gate_ctrl.sv
module gate_ctrl
  import chain_sum_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic desc_vld_i,
  input  logic sum_match_i,
  input  logic err_clr_i,
  output logic halt_o,
  output logic err_o,
  output logic irq_o,
  output logic load_ok_o
);
  chain_state_e state_q, state_d;
  logic err_q, irq_q, ok_q;
  logic chk, pass, fail;

  assign chk  = desc_vld_i && !start_i && (state_q == CHAIN_RUN);
  assign pass = chk && sum_match_i;
  assign fail = chk && !sum_match_i;

  always_comb begin
    state_d = state_q;
    if (start_i)   state_d = CHAIN_RUN;
    else if (fail) state_d = CHAIN_HALT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CHAIN_RUN;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= fail;
      ok_q    <= pass;
      if (fail)           err_q <= 1'b1;
      else if (err_clr_i) err_q <= 1'b0;
    end
  end

  assign halt_o    = (state_q == CHAIN_HALT);
  assign err_o     = err_q;
  assign irq_o     = irq_q;
  assign load_ok_o = ok_q;
endmodule

// File: rtl/chain_sum_gate.sv
module chain_sum_gate
  import chain_sum_pkg::*;
#(
  parameter int unsigned        W    = SUM_W,
  parameter logic [W-1:0]       POLY = SUM_POLY,
  parameter logic [W-1:0]       INIT = SUM_INIT
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         chain_start_i,
  input  logic         addr_vld_i,
  input  logic [W-1:0] addr_i,
  input  logic         rdata_vld_i,
  input  logic [W-1:0] rdata_i,
  input  logic         desc_vld_i,
  input  logic [W-1:0] desc_sum_i,
  input  logic         err_clr_i,
  output logic [W-1:0] addr_crc_o,
  output logic [W-1:0] data_crc_o,
  output logic         load_ok_o,
  output logic         halt_o,
  output logic         err_o,
  output logic         irq_o
);
  localparam int unsigned NSUM = 2;

  logic [NSUM-1:0]        upd;
  logic [NSUM-1:0][W-1:0] word, sum;

  assign upd  = {rdata_vld_i, addr_vld_i};
  assign word = {rdata_i, addr_i};

  for (genvar g = 0; g < NSUM; g++) begin : g_sum
    sum_accum #(.W(W), .POLY(POLY), .INIT(INIT)) u_sum (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .seed_i (chain_start_i),
      .hold_i (halt_o),
      .upd_i  (upd[g]),
      .word_i (word[g]),
      .sum_o  (sum[g])
    );
  end

  assign addr_crc_o = sum[0];
  assign data_crc_o = sum[1];

  gate_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (chain_start_i),
    .desc_vld_i  (desc_vld_i),
    .sum_match_i (desc_sum_i == sum[0]),
    .err_clr_i   (err_clr_i),
    .halt_o      (halt_o),
    .err_o       (err_o),
    .irq_o       (irq_o),
    .load_ok_o   (load_ok_o)
  );
endmodule

// File: rtl/chain_sum_gate_chk.sv
module chain_sum_gate_chk #(
  parameter int unsigned  W    = 32,
  parameter logic [W-1:0] INIT = '1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         chain_start_i,
  input logic         desc_vld_i,
  input logic [W-1:0] desc_sum_i,
  input logic         err_clr_i,
  input logic [W-1:0] addr_crc_o,
  input logic [W-1:0] data_crc_o,
  input logic         load_ok_o,
  input logic         halt_o,
  input logic         err_o,
  input logic         irq_o
);
  // R7
  irq_one_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R7
  irq_with_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (err_o && halt_o && !load_ok_o));
  // R8
  halt_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !chain_start_i) |=> ($stable(addr_crc_o) && $stable(data_crc_o) && !load_ok_o));
  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o);
  // R4
  start_seed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_start_i |=> (addr_crc_o == INIT && data_crc_o == INIT && !halt_o));
  // R5
  match_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_vld_i && !halt_o && !chain_start_i && desc_sum_i == addr_crc_o) |=> (load_ok_o && !irq_o));
endmodule

bind chain_sum_gate chain_sum_gate_chk #(.W(W), .INIT(INIT)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .chain_start_i (chain_start_i),
  .desc_vld_i    (desc_vld_i),
  .desc_sum_i    (desc_sum_i),
  .err_clr_i     (err_clr_i),
  .addr_crc_o    (addr_crc_o),
  .data_crc_o    (data_crc_o),
  .load_ok_o     (load_ok_o),
  .halt_o        (halt_o),
  .err_o         (err_o),
  .irq_o         (irq_o)
);

// File: tb/tb_chain_sum_gate.sv
module tb_chain_sum_gate;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] POLY = 32'h04C1_1DB7;
  localparam logic [31:0] INIT = 32'hFFFF_FFFF;
  localparam int NVEC = 6;
  // {addr_en, data_en, addr, data}
  localparam logic [65:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 32'h0000_0000, 32'h0000_0000},
    {1'b1, 1'b0, 32'h7000_0020, 32'hDEAD_BEEF},
    {1'b0, 1'b1, 32'h1234_5678, 32'hA5A5_5A5A},
    {1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0000_0001},
    {1'b0, 1'b0, 32'h8000_0000, 32'h8000_0000},
    {1'b1, 1'b1, 32'h8000_0004, 32'h3C3C_3C3C}
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        chain_start_i = 0, addr_vld_i = 0, rdata_vld_i = 0, desc_vld_i = 0, err_clr_i = 0;
  logic [31:0] addr_i = '0, rdata_i = '0, desc_sum_i = '0;
  logic [31:0] addr_crc_o, data_crc_o;
  logic        load_ok_o, halt_o, err_o, irq_o;

  int checks = 0, errors = 0;
  logic [31:0] m_addr, m_data;

  chain_sum_gate dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [31:0] crc_upd(logic [31:0] c, logic [31:0] d);
    for (int i = 31; i >= 0; i--) begin
      logic fb;
      fb = c[31] ^ d[i];
      c  = c << 1;
      if (fb) c ^= POLY;
    end
    return c;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    chain_start_i = 0; addr_vld_i = 0; rdata_vld_i = 0; desc_vld_i = 0; err_clr_i = 0;
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
    idle_in();
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    // R1 reset state
    chk("R1 addr", addr_crc_o, INIT);
    chk("R1 data", data_crc_o, INIT);
    chk("R1 flags", {28'd0, halt_o, err_o, irq_o, load_ok_o}, 32'd0);
    @(negedge clk_i); rst_ni = 1;
    @(posedge clk_i); #1;
    m_addr = INIT; m_data = INIT;

    // R2 R3 vector walk
    for (int v = 0; v < NVEC; v++) begin
      addr_vld_i = VEC[v][65]; rdata_vld_i = VEC[v][64];
      addr_i = VEC[v][63:32]; rdata_i = VEC[v][31:0];
      if (VEC[v][65]) m_addr = crc_upd(m_addr, VEC[v][63:32]);
      if (VEC[v][64]) m_data = crc_upd(m_data, VEC[v][31:0]);
      tick();
      chk("R2 addr crc", addr_crc_o, m_addr);
      chk("R3 data crc", data_crc_o, m_data);
    end

    // R5 matching descriptor
    desc_vld_i = 1; desc_sum_i = m_addr;
    tick();
    chk("R5 load_ok", {31'd0, load_ok_o}, 32'd1);
    chk("R5 no irq", {30'd0, irq_o, halt_o}, 32'd0);
    tick();
    chk("R5 load_ok one cycle", {31'd0, load_ok_o}, 32'd0);

    // R6 accumulation continues past commit
    addr_vld_i = 1; addr_i = 32'h9000_0040; rdata_vld_i = 1; rdata_i = 32'h0BAD_F00D;
    m_addr = crc_upd(m_addr, 32'h9000_0040); m_data = crc_upd(m_data, 32'h0BAD_F00D);
    tick();
    chk("R6 addr continues", addr_crc_o, m_addr);
    chk("R6 data continues", data_crc_o, m_data);

    // R10 R7 sum equals data checksum only -> mismatch
    desc_vld_i = 1; desc_sum_i = m_data;
    tick();
    chk("R10 R7 irq", {31'd0, irq_o}, 32'd1);
    chk("R7 err halt", {30'd0, err_o, halt_o}, 32'd3);
    chk("R7 no load_ok", {31'd0, load_ok_o}, 32'd0);
    tick();
    chk("R7 irq one cycle", {31'd0, irq_o}, 32'd0);

    // R8 halted: inputs ignored
    addr_vld_i = 1; addr_i = 32'h1; rdata_vld_i = 1; rdata_i = 32'h2;
    desc_vld_i = 1; desc_sum_i = m_addr;
    tick();
    chk("R8 addr held", addr_crc_o, m_addr);
    chk("R8 data held", data_crc_o, m_data);
    chk("R8 no pulses", {30'd0, load_ok_o, irq_o}, 32'd0);

    // R9 sticky then cleared; halt stays
    tick(); tick();
    chk("R9 err sticky", {31'd0, err_o}, 32'd1);
    err_clr_i = 1;
    tick();
    chk("R9 err cleared", {31'd0, err_o}, 32'd0);
    chk("R9 halt kept", {31'd0, halt_o}, 32'd1);

    // R4 start overrides same-cycle move and descriptor
    chain_start_i = 1; addr_vld_i = 1; addr_i = 32'h55; desc_vld_i = 1; desc_sum_i = 32'h0;
    tick();
    chk("R4 addr seed", addr_crc_o, INIT);
    chk("R4 data seed", data_crc_o, INIT);
    chk("R4 released", {29'd0, halt_o, irq_o, load_ok_o}, 32'd0);
    m_addr = INIT; m_data = INIT;

    // R9 new mismatch wins over clear
    desc_vld_i = 1; desc_sum_i = 32'h1234_0000; err_clr_i = 1;
    tick();
    chk("R9 set wins", {31'd0, err_o}, 32'd1);
    chk("R7 halt after second mismatch", {31'd0, halt_o}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule